// File: doc/BRIEF.md
# Multi-cycle register-file processor

This block is a small controller-plus-datapath processor for sequencing simple jobs out of one shared memory. Each instruction is one 16-bit word. The controller reads the word at the program counter, spends one cycle decoding its 4-bit opcode, and then takes exactly one execute cycle before it fetches again. Every instruction therefore takes three cycles.

The datapath has sixteen 16-bit registers with two read ports and one write port, an ALU that can add, subtract or pass an operand through, and two selectors. One selector picks the register write source: the ALU, memory read data or the immediate field. The other picks the memory address: the program counter, the direct field or a register. A single word-addressed memory port carries both instruction fetches and data accesses. The read data must be valid in the same cycle as the address and the read strobe. A write takes effect at the clock edge that ends the strobe cycle. An opcode outside the defined set stops the controller for good, until the next reset.

Top module: `fsmd_cpu`

## Requirements
- R1: While reset is high and in the cycle after it, the block fetches from address 0 with the read strobe high, the write strobe low and halt low. Reset also clears all sixteen registers to 0.
- R2: Each instruction takes exactly three cycles: fetch, decode, then one execute cycle. The fetch cycle reads the word at the program counter, and the counter then holds that value plus one. A program of N legal instructions followed by an illegal one raises halt 3N+2 cycles after reset is released.
- R3: The instruction word is laid out as follows. Bits [15:12] hold the opcode and bits [11:8] select Rn. Bits [7:4] select Rm, and bits [7:0] hold the direct address, the immediate or the jump offset.
- R4: Opcode 0x0 loads Rn from memory at the zero-extended direct address.
- R5: Opcode 0x1 writes Rn to memory at the zero-extended direct address.
- R6: Opcode 0x2 writes Rm to memory at the address held in Rn.
- R7: Opcode 0x3 loads Rn with the 8-bit immediate, zero-extended to 16 bits.
- R8: Opcode 0x4 sets Rn to Rn+Rm and opcode 0x5 sets Rn to Rn-Rm, both wrapping modulo 2^16.
- R9: Opcode 0x6 adds the sign-extended 8-bit offset to the already-incremented program counter when Rn is zero. When Rn is not zero, execution continues with the next word.
- R10: Opcodes 0x7 to 0xF raise halt two cycles after their fetch begins. Halt then stays high with both strobes low until reset.
- R11: The read and write strobes are never high together, and both are low in the decode cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Word address of the memory access |
| mem_wdata | output | 16 | Data to store |
| mem_rdata | input | 16 | Read data, valid in the same cycle as the address |
| mem_rd | output | 1 | Read strobe (fetch or load) |
| mem_wr | output | 1 | Write strobe, memory written at the closing clock edge |
| halted | output | 1 | High once an illegal opcode has been decoded |

## Verification
Every instruction takes exactly three cycles. After reset is released, the bench expects the decode cycle after one clock edge and the second fetch after three. It expects halt after exactly 3N+2 edges, where N is the number of legal instructions that a reference model in the bench counts while it runs the same program. The bench samples at the falling edge, so each check sees the state left by the last rising edge. Memory contents are compared only once halt is up, when no further write can come. Directed programs cover wrap-around, zero extension, indirect stores, jumps that are taken and not taken, and a backward loop. Random programs with a fixed seed fill in the rest.

// File: rtl/fsmd_cpu.sv
module fsmd_cpu #(
  parameter int DW   = 16,
  parameter int AW   = 16,
  parameter int NREG = 16,
  parameter int OPW  = 4
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          halted
);
  localparam int RW = $clog2(NREG);
  localparam int FW = DW - OPW - RW;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_LDD, S_STD, S_STI, S_LDI, S_ADD, S_SUB, S_JZ, S_HALT
  } state_t;

  typedef struct packed {
    logic       ir_ld;
    logic       pc_inc;
    logic       pc_jz;
    logic       rf_we;
    logic [1:0] rf_sel;
    logic [1:0] alu_op;
    logic [1:0] am_sel;
    logic       rd;
    logic       wr;
    logic       wd_rm;
  } ctl_t;

  state_t        state, nxt;
  ctl_t          ctl;
  logic [AW-1:0] pc;
  logic [DW-1:0] ir;
  logic [DW-1:0] rf [NREG];
  logic [DW-1:0] r1, r2, alu_y, rf_wd;
  logic          alu_z, fetching;

  wire [OPW-1:0] op  = ir[DW-1 -: OPW];
  wire [RW-1:0]  rn  = ir[DW-OPW-1 -: RW];
  wire [RW-1:0]  rm  = ir[FW-1 -: RW];
  wire [FW-1:0]  low = ir[FW-1:0];

  assign r1 = rf[rn];
  assign r2 = rf[rm];

  always_comb begin
    ctl = '0;
    case (state)
      S_FETCH: begin ctl.am_sel = 2'd0; ctl.rd = 1'b1; ctl.ir_ld = 1'b1; ctl.pc_inc = 1'b1; end
      S_LDD:   begin ctl.am_sel = 2'd1; ctl.rd = 1'b1; ctl.rf_we = 1'b1; ctl.rf_sel = 2'd1; end
      S_STD:   begin ctl.am_sel = 2'd1; ctl.wr = 1'b1; end
      S_STI:   begin ctl.am_sel = 2'd2; ctl.wr = 1'b1; ctl.wd_rm = 1'b1; end
      S_LDI:   begin ctl.rf_we = 1'b1; ctl.rf_sel = 2'd2; end
      S_ADD:   begin ctl.rf_we = 1'b1; ctl.rf_sel = 2'd0; ctl.alu_op = 2'd0; end
      S_SUB:   begin ctl.rf_we = 1'b1; ctl.rf_sel = 2'd0; ctl.alu_op = 2'd1; end
      S_JZ:    begin ctl.alu_op = 2'd2; ctl.pc_jz = 1'b1; end
      default: ctl = '0;
    endcase
  end

  always_comb begin
    case (state)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE:
        case (op)
          4'h0:    nxt = S_LDD;
          4'h1:    nxt = S_STD;
          4'h2:    nxt = S_STI;
          4'h3:    nxt = S_LDI;
          4'h4:    nxt = S_ADD;
          4'h5:    nxt = S_SUB;
          4'h6:    nxt = S_JZ;
          default: nxt = S_HALT;
        endcase
      S_HALT:   nxt = S_HALT;
      default:  nxt = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH;
    else     state <= nxt;
  end

  always_comb begin
    case (ctl.alu_op)
      2'd0:    alu_y = r1 + r2;
      2'd1:    alu_y = r1 - r2;
      default: alu_y = r1;
    endcase
  end
  assign alu_z = (alu_y == '0);

  always_comb begin
    case (ctl.rf_sel)
      2'd1:    rf_wd = mem_rdata;
      2'd2:    rf_wd = {{(DW-FW){1'b0}}, low};
      default: rf_wd = alu_y;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (ctl.rf_we) begin
      rf[rn] <= rf_wd;
    end
  end

  assign fetching = ctl.ir_ld;

  always_ff @(posedge clk) begin
    if (rst)                    pc <= '0;
    else if (ctl.pc_inc)        pc <= pc + 1'b1;
    else if (ctl.pc_jz && alu_z) pc <= pc + {{(AW-FW){low[FW-1]}}, low};
  end

  always_ff @(posedge clk) begin
    if (rst)           ir <= '0;
    else if (fetching) ir <= mem_rdata;
  end

  always_comb begin
    case (ctl.am_sel)
      2'd1:    mem_addr = {{(AW-FW){1'b0}}, low};
      2'd2:    mem_addr = r1[AW-1:0];
      default: mem_addr = pc;
    endcase
  end

  assign mem_wdata = ctl.wd_rm ? r2 : r1;
  assign mem_rd    = ctl.rd;
  assign mem_wr    = ctl.wr;
  assign halted    = (state == S_HALT);
endmodule

module fsmd_cpu_props #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          halted,
  input logic [AW-1:0] pc,
  input logic          fetching
);
  p_reset_fetch_r1: assert property (@(posedge clk)
    rst |=> (mem_rd && !mem_wr && !halted && mem_addr == '0));

  p_fetch_at_pc_r2: assert property (@(posedge clk) disable iff (rst)
    fetching |-> (mem_rd && mem_addr == pc));

  p_fetch_advance_r2: assert property (@(posedge clk) disable iff (rst)
    fetching |=> (pc == $past(pc) + 1'b1));

  p_store_then_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> (fetching && !mem_wr));

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  p_halt_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_rd && !mem_wr));
endmodule

bind fsmd_cpu fsmd_cpu_props #(.AW(AW)) u_props (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .halted(halted), .pc(pc), .fetching(fetching)
);

// File: tb/test_fsmd_cpu.sv
module test_fsmd_cpu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr, halted;

  int checks = 0;
  int errors = 0;
  int total_cyc = 0;

  logic [15:0] dmem [256];
  logic [15:0] img  [256];
  logic [15:0] refm [256];
  logic [15:0] rreg [16];
  int          plen;

  always #4 clk = ~clk;

  fsmd_cpu i_fsmd_cpu (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .halted(halted)
  );

  assign mem_rdata = dmem[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) dmem[mem_addr[7:0]] <= mem_wdata;

  always @(posedge clk) begin
    total_cyc++;
    if (total_cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, act %0d cycles exp < 150000", total_cyc);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act 0x%0h exp 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input int op, input int rn, input int lo);
    return {op[3:0], rn[3:0], lo[7:0]};
  endfunction

  task automatic put(input logic [15:0] w);
    img[plen[7:0]] = w;
    plen++;
  endtask

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = 16'h0000;
    plen = 0;
  endtask

  function automatic int ref_run();
    logic [15:0] pc, ir;
    int n;
    pc = 0;
    n = 0;
    for (int i = 0; i < 16; i++) rreg[i] = 16'h0;
    while (n < 20000) begin
      ir = refm[pc[7:0]];
      pc = pc + 1;
      case (ir[15:12])
        4'h0: rreg[ir[11:8]] = refm[ir[7:0]];
        4'h1: refm[ir[7:0]] = rreg[ir[11:8]];
        4'h2: refm[rreg[ir[11:8]][7:0]] = rreg[ir[7:4]];
        4'h3: rreg[ir[11:8]] = {8'h00, ir[7:0]};
        4'h4: rreg[ir[11:8]] = rreg[ir[11:8]] + rreg[ir[7:4]];
        4'h5: rreg[ir[11:8]] = rreg[ir[11:8]] - rreg[ir[7:4]];
        4'h6: if (rreg[ir[11:8]] == 16'h0) pc = pc + {{8{ir[7]}}, ir[7:0]};
        default: return n;
      endcase
      n++;
    end
    return -1;
  endfunction

  task automatic run_prog(input string name);
    int n, cyc, bad, first;
    for (int i = 0; i < 256; i++) begin dmem[i] = img[i]; refm[i] = img[i]; end
    n = ref_run();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(mem_rd && !mem_wr && !halted && mem_addr == 16'h0, "R1", {name, " reset fetch"},
        {13'h0, mem_rd, mem_wr, halted, mem_addr}, 32'h0004_0000);
    rst = 1'b0;
    cyc = 0;
    while (!halted && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1)
        chk(!mem_rd && !mem_wr, "R11", {name, " decode strobes"}, {mem_rd, mem_wr}, 0);
      if (cyc == 3)
        chk(mem_rd && mem_addr == 16'h1, "R2", {name, " second fetch addr"}, mem_addr, 1);
    end
    chk(cyc == 3 * n + 2, "R2", {name, " cycles to halt"}, cyc, 3 * n + 2);
    repeat (5) @(negedge clk);
    chk(halted && !mem_rd && !mem_wr, "R10", {name, " halt sticky and quiet"},
        {halted, mem_rd, mem_wr}, 3'b100);
    bad = 0;
    first = -1;
    for (int i = 0; i < 256; i++)
      if (dmem[i] !== refm[i]) begin bad++; if (first < 0) first = i; end
    if (first < 0) first = 0;
    chk(bad == 0, "R3", {name, " memory image vs model"}, dmem[first], refm[first]);
  endtask

  task automatic gen_random();
    int k, r, s;
    clear_img();
    for (int i = 0; i < 16; i++) put(enc(3, i, $urandom % 256));
    while (plen < 'h60) begin
      k = $urandom % 7;
      r = $urandom % 16;
      s = $urandom % 16;
      case (k)
        0: put(enc(0, r, 'h80 + $urandom % 'h70));
        1: put(enc(1, r, 'h80 + $urandom % 'h70));
        2: begin
             if (s == r) s = (r + 1) % 16;
             put(enc(3, r, 'h80 + $urandom % 'h70));
             put(enc(2, r, s << 4));
           end
        3: put(enc(3, r, $urandom % 256));
        4: put(enc(4, r, s << 4));
        5: put(enc(5, r, s << 4));
        default: begin
             if ($urandom % 2) put(enc(5, r, r << 4));
             put(enc(6, r, 1));
             put(enc(3, s, $urandom % 256));
           end
      endcase
    end
    for (int i = 0; i < 16; i++) put(enc(1, i, 'hF0 + i));
    put({4'(7 + $urandom % 9), 12'($urandom)});
    for (int i = 'h80; i < 'hF0; i++) img[i] = 16'($urandom);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) dmem[i] = 16'h0;

    // directed: zero extension, wrap, indirect store, direct load, jumps
    clear_img();
    put(enc(3, 1, 'hFF));
    put(enc(3, 2, 0));
    put(enc(3, 3, 1));
    put(enc(5, 2, 3 << 4));
    put(enc(3, 5, 0));
    put(enc(5, 5, 3 << 4));
    put(enc(4, 5, 3 << 4));
    put(enc(1, 1, 'hF1));
    put(enc(1, 2, 'hF2));
    put(enc(1, 5, 'hF3));
    put(enc(3, 6, 'hA0));
    put(enc(3, 7, 'h5A));
    put(enc(2, 6, 7 << 4));
    put(enc(0, 8, 'hA0));
    put(enc(1, 8, 'hF4));
    put(enc(6, 3, 1));
    put(enc(1, 3, 'hF5));
    put(enc(6, 5, 1));
    put(enc(3, 9, 'h77));
    put(enc(1, 9, 'hF6));
    put(16'hF000);
    run_prog("directed");
    chk(dmem['hF1] == 16'h00FF, "R7", "immediate zero-extended", dmem['hF1], 16'h00FF);
    chk(dmem['hF2] == 16'hFFFF, "R8", "0-1 wraps", dmem['hF2], 16'hFFFF);
    chk(dmem['hF3] == 16'h0000, "R8", "0xFFFF+1 wraps", dmem['hF3], 16'h0000);
    chk(dmem['hA0] == 16'h005A, "R6", "indirect store", dmem['hA0], 16'h005A);
    chk(dmem['hF4] == 16'h005A, "R4", "direct load", dmem['hF4], 16'h005A);
    chk(dmem['hF5] == 16'h0001, "R9", "jump not taken", dmem['hF5], 16'h0001);
    chk(dmem['hF6] == 16'h0000, "R9", "jump taken skips write", dmem['hF6], 16'h0000);
    chk(dmem['hF6] == 16'h0000, "R1", "register cleared by reset", dmem['hF6], 16'h0000);

    // directed: countdown loop with backward jump
    clear_img();
    put(enc(3, 0, 0));
    put(enc(3, 1, 10));
    put(enc(3, 2, 1));
    put(enc(3, 3, 0));
    put(enc(6, 1, 3));
    put(enc(4, 0, 1 << 4));
    put(enc(5, 1, 2 << 4));
    put(enc(6, 3, 'hFC));
    put(enc(1, 0, 'hF0));
    put(16'h7ABC);
    run_prog("loop");
    chk(dmem['hF0] == 16'd55, "R9", "backward loop sum", dmem['hF0], 16'd55);
    chk(dmem['hF0] == 16'd55, "R5", "direct store of result", dmem['hF0], 16'd55);

    for (int t = 0; t < 20; t++) begin
      gen_random();
      run_prog($sformatf("random%0d", t));
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule